// File: doc/BRIEF.md
# Packet Interface Transmit Scheduler

This block decides, one word per clock, what the transmit side of a 16-bit packet interface carries. There are three kinds of traffic: payload bursts taken from a transmit FIFO, idle control words, and training sequences. Payload reaches the block on a valid/ready stream. A low `in_valid` means the FIFO is empty. `in_valid` must stay high, with the word and its flags held steady, until the word is accepted (`in_valid && in_ready`). `in_ready` is high only while a burst is in progress. The output side has no back-pressure: a new word appears on `out_word` on every clock, and `out_type` says which kind it is.

Payload moves in bursts of at most `BURST_BYTES` bytes. A burst ends earlier at an end of packet, at an error-marked word, or when the FIFO runs dry partway through. Every burst opens with a start control word and is closed by the next control word. That closing word may be idle or start another burst. It reports whether the packet ended and carries a 4-bit diagonal parity over the burst and over itself. An external grant input gates the start of each burst.

A user idle request holds off new bursts but never cuts one short. A training request is latched and always outranks both idle and data. When the user marks a word as erroneous without an end of packet, the packet is closed there and the closing control word carries a deliberately inverted parity for diagnostics.

Top module: `tx_burst_scheduler`

## Requirements
- R1: While `rst_n` is low, `out_type` is 0, `out_word` is 0, `dip4_bad` is 0 and `in_ready` is 0. The state is a closed burst boundary, and the next packet starts a new packet.
- R2: At a burst boundary, the block emits an idle word (`out_type`=0) if the FIFO is empty, if `grant` is low, or if `idle_req` is high. The idle word is `{1'b0, eop, 1'b0, 9'b0, dip4}`.
- R3: At a burst boundary with no training pending, `in_valid` high, `grant` high and `idle_req` low, the block emits a start word (`out_type`=1). The start word is `{1'b1, eop, sop, 9'b0, dip4}`. From the next cycle `in_ready` is high. Each accepted word appears one cycle later as `out_type`=2 with `out_word` equal to the accepted data.
- R4: A burst closes after `BURST_BYTES/2` words (8 by default), or after a word with `in_eop` or `in_err` high. If `in_valid` is low during a burst, the burst closes at once: an idle word is emitted in that cycle and `eop` is clear.
- R5: Raising `idle_req` during a burst does not shorten it. The burst runs to its normal end, and idle words follow for as long as the request stays high.
- R6: `dip4` is computed as follows. Start a 16-bit accumulator at 0. For each data word w of the burst, set acc = rotl1(acc) ^ w. Then fold in the control word with its low 4 bits set to 1111 in the same way. Bit i of `dip4` is the XOR of accumulator bits i, i+4, i+8 and i+12. An idle or start word with no preceding data covers only itself.
- R7: Bit 14 (`eop`) of a control word is set when the burst it closes ended its packet. Bit 13 (`sop`) of a start word is set only when the burst begins a packet.
- R8: A word with `in_err` high and `in_eop` low ends its packet. The next control word has `eop` set, its low 4 bits equal to the bitwise inverse of the correct `dip4`, and `dip4_bad` high. If `in_err` and `in_eop` are both high, the packet ends normally and `dip4` is correct.
- R9: A cycle with `train_req` high makes training pending. At the next burst boundary, training wins over data and idle. The sequence is one idle (closing) word, then `TRAIN_REPS` repetitions of `TRAIN_PAT_LEN` words of 16'h0FFF (`out_type`=3) followed by `TRAIN_PAT_LEN` words of 16'hF000 (`out_type`=4). After the sequence, scheduling resumes at a boundary.
- R10: Training words do not enter the parity. The first control word after a training sequence carries a `dip4` over itself alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | FIFO word present (low means FIFO empty) |
| in_ready | output | 1 | Block takes a word this cycle |
| in_data | input | 16 | Payload word |
| in_eop | input | 1 | Word is the last of its packet |
| in_err | input | 1 | User error marker on this word |
| grant | input | 1 | A new burst may start |
| idle_req | input | 1 | Hold off new bursts, send idle |
| train_req | input | 1 | Request a training sequence |
| out_type | output | 3 | 0 idle, 1 start, 2 data, 3 training control, 4 training data |
| out_word | output | 16 | Word on the interface |
| dip4_bad | output | 1 | Current control word carries an inverted parity |

## Verification
The hardest situation to reach from the ports is a training request and an idle request that meet at the same burst boundary while payload is still queued. The stimulus holds `idle_req` high, pulses `train_req`, and keeps the FIFO non-empty, so the boundary has to choose between all three. The mid-burst FIFO underrun is also difficult: the packet is pushed in two parts with a drained gap between them. A cycle-accurate model in the bench covers both cases, checking every word and every parity value.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    WT_IDLE = 3'd0,
    WT_CTRL = 3'd1,
    WT_DATA = 3'd2,
    WT_TCTL = 3'd3,
    WT_TDAT = 3'd4
  } word_type_e;

  localparam logic [WORD_W-1:0] TRAIN_CTRL_PAT = 16'h0FFF;
  localparam logic [WORD_W-1:0] TRAIN_DATA_PAT = 16'hF000;

  function automatic logic [WORD_W-1:0] rotl1(input logic [WORD_W-1:0] a);
    return {a[WORD_W-2:0], a[WORD_W-1]};
  endfunction

  function automatic logic [3:0] fold4(input logic [WORD_W-1:0] w);
    logic [3:0] r;
    r = '0;
    for (int i = 0; i < WORD_W/4; i++) r ^= w[4*i +: 4];
    return r;
  endfunction
endpackage

// File: rtl/tx_dip4_acc.sv
module tx_dip4_acc
  import tx_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add_en,
  input  logic [WORD_W-1:0] add_word,
  input  logic [WORD_W-1:0] cw_nodip,
  output logic [3:0]        dip4
);
  logic [WORD_W-1:0] acc;

  // parity of everything since the last control word, closed by the control word
  assign dip4 = fold4(rotl1(acc) ^ cw_nodip);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clear)  acc <= '0;
    else if (add_en) acc <= rotl1(acc) ^ add_word;
  end

  // R6
  no_clear_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> acc == '0);
endmodule

// File: rtl/tx_train_seq.sv
module tx_train_seq #(
  parameter int PAT_LEN = 10,
  parameter int REPS    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic phase_data,
  output logic last
);
  localparam int PW = $clog2(PAT_LEN + 1);
  localparam int RW = $clog2(REPS + 1);

  logic [PW-1:0] pos;
  logic [RW-1:0] rep;
  logic          pos_end;

  assign pos_end = (pos == PW'(PAT_LEN - 1));
  assign last    = busy && phase_data && pos_end && (rep == RW'(REPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; phase_data <= 1'b0; pos <= '0; rep <= '0;
    end else if (start) begin
      busy <= 1'b1; phase_data <= 1'b0; pos <= '0; rep <= '0;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      if (pos_end) begin
        pos        <= '0;
        phase_data <= ~phase_data;
        if (phase_data) rep <= rep + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/tx_burst_scheduler.sv
module tx_burst_scheduler
  import tx_sched_pkg::*;
#(
  parameter int BURST_BYTES   = 16,
  parameter int TRAIN_PAT_LEN = 10,
  parameter int TRAIN_REPS    = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_data,
  input  logic        in_eop,
  input  logic        in_err,
  input  logic        grant,
  input  logic        idle_req,
  input  logic        train_req,
  output logic [2:0]  out_type,
  output logic [15:0] out_word,
  output logic        dip4_bad
);
  localparam int BURST_WORDS = BURST_BYTES / 2;
  localparam int CW          = $clog2(BURST_WORDS + 1);

  typedef enum logic [1:0] {S_GAP, S_BURST, S_TRAIN} sched_st_e;

  sched_st_e   st;
  logic [CW-1:0] cnt;
  logic        eop_pend, bad_pend, pkt_first, train_pend;
  logic        accept, go_burst, go_train, word_last, acc_clear;
  logic [15:0] cw_nodip;
  logic [3:0]  dip4;
  logic        seq_busy, seq_data, seq_last;

  assign in_ready  = (st == S_BURST);
  assign accept    = in_ready && in_valid;
  assign go_train  = (st == S_GAP) && train_pend;
  assign go_burst  = (st == S_GAP) && !train_pend && !idle_req && in_valid && grant;
  assign word_last = accept && (in_eop || in_err || cnt == CW'(BURST_WORDS - 1));
  assign cw_nodip  = {go_burst, eop_pend, go_burst & pkt_first, 9'd0, 4'hF};
  assign acc_clear = (st == S_GAP) || (st == S_TRAIN) || (st == S_BURST && !in_valid);

  tx_dip4_acc u_dip (
    .clk(clk), .rst_n(rst_n), .clear(acc_clear), .add_en(accept),
    .add_word(in_data), .cw_nodip(cw_nodip), .dip4(dip4)
  );

  tx_train_seq #(.PAT_LEN(TRAIN_PAT_LEN), .REPS(TRAIN_REPS)) u_train (
    .clk(clk), .rst_n(rst_n), .start(go_train),
    .busy(seq_busy), .phase_data(seq_data), .last(seq_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_GAP; cnt <= '0;
      eop_pend <= 1'b0; bad_pend <= 1'b0; pkt_first <= 1'b1; train_pend <= 1'b0;
      out_type <= WT_IDLE; out_word <= '0; dip4_bad <= 1'b0;
    end else begin
      train_pend <= (train_pend & ~go_train) | train_req;
      unique case (st)
        S_GAP: begin
          out_type <= go_burst ? WT_CTRL : WT_IDLE;
          out_word <= {cw_nodip[15:4], bad_pend ? ~dip4 : dip4};
          dip4_bad <= bad_pend;
          eop_pend <= 1'b0;
          bad_pend <= 1'b0;
          if (go_train) st <= S_TRAIN;
          else if (go_burst) begin
            st  <= S_BURST;
            cnt <= '0;
          end
        end
        S_BURST: begin
          dip4_bad <= 1'b0;
          if (accept) begin
            out_type  <= WT_DATA;
            out_word  <= in_data;
            cnt       <= cnt + 1'b1;
            pkt_first <= in_eop | in_err;
            if (word_last) begin
              st       <= S_GAP;
              eop_pend <= in_eop | in_err;
              bad_pend <= in_err & ~in_eop;
            end
          end else begin
            // FIFO ran dry mid-burst: close it here with an idle word
            out_type <= WT_IDLE;
            out_word <= {cw_nodip[15:4], dip4};
            st       <= S_GAP;
          end
        end
        default: begin
          out_type <= seq_data ? WT_TDAT : WT_TCTL;
          out_word <= seq_data ? TRAIN_DATA_PAT : TRAIN_CTRL_PAT;
          dip4_bad <= 1'b0;
          if (seq_last) st <= S_GAP;
        end
      endcase
    end
  end

  // R3
  accept_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_type == WT_DATA);
  // R3
  ctrl_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP && !grant) |=> out_type != WT_CTRL);
  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BURST) |-> cnt < CW'(BURST_WORDS));
  // R8
  bad_dip_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dip4_bad |-> (out_word[14] && (out_type == WT_IDLE || out_type == WT_CTRL)));
  // R9
  train_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP && train_pend) |=> (st == S_TRAIN && out_type == WT_IDLE && seq_busy));
endmodule

// File: tb/test_tx_burst_scheduler.sv
module test_tx_burst_scheduler;
  localparam int BW = 8, PAT = 10, REPS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_eop = 1'b0, in_err = 1'b0;
  logic [15:0] in_data = '0;
  logic grant = 1'b0, idle_req = 1'b0, train_req = 1'b0;
  logic in_ready, dip4_bad;
  logic [2:0] out_type;
  logic [15:0] out_word;

  tx_burst_scheduler i_tx_burst_scheduler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_eop(in_eop), .in_err(in_err), .grant(grant),
    .idle_req(idle_req), .train_req(train_req), .out_type(out_type),
    .out_word(out_word), .dip4_bad(dip4_bad)
  );

  always #10 clk = ~clk;

  typedef struct packed {logic [15:0] d; logic e; logic r;} wd_t;
  wd_t q[$];
  int checks = 0, failures = 0;
  bit chk_on = 0, done = 0;
  string cur_req = "R2";
  logic [31:0] seed = 32'h1234_5678;

  // reference model state
  int m_st = 0, m_cnt = 0, m_t = 0;
  bit m_eop = 0, m_bad = 0, m_first = 1, m_tpend = 0;
  logic [15:0] m_acc = '0;
  int exp_type = 0, exp_bad = 0, exp_ready = 0;
  logic [15:0] exp_word = '0;

  function automatic logic [15:0] rl(input logic [15:0] a);
    return {a[14:0], a[15]};
  endfunction
  function automatic logic [3:0] fd(input logic [15:0] w);
    logic [3:0] r;
    for (int b = 0; b < 4; b++) r[b] = w[b] ^ w[b+4] ^ w[b+8] ^ w[b+12];
    return r;
  endfunction

  task automatic emit_cw(input bit start_burst);
    logic [15:0] nod;
    logic [3:0] f;
    nod = {start_burst, m_eop, start_burst & m_first, 9'd0, 4'hF};
    f = fd(rl(m_acc) ^ nod);
    exp_word = {nod[15:4], m_bad ? ~f : f};
    exp_bad = m_bad;
    exp_type = start_burst ? 1 : 0;
    m_acc = '0; m_eop = 0; m_bad = 0;
  endtask

  always @(posedge clk) begin
    bit started;
    started = 0;
    if (rst_n) begin
      case (m_st)
        0: if (m_tpend) begin emit_cw(0); m_st = 2; m_t = 0; started = 1; end
           else if (!idle_req && in_valid && grant) begin emit_cw(1); m_st = 1; m_cnt = 0; end
           else emit_cw(0);
        1: if (in_valid) begin
             exp_type = 2; exp_word = in_data; exp_bad = 0;
             m_acc = rl(m_acc) ^ in_data; m_cnt++;
             m_first = in_eop | in_err;
             void'(q.pop_front());
             if (in_eop || in_err || m_cnt == BW) begin
               m_st = 0; m_eop = in_eop | in_err; m_bad = in_err & !in_eop;
             end
           end else begin emit_cw(0); m_st = 0; end
        default: begin
          exp_type = ((m_t / PAT) % 2) ? 4 : 3;
          exp_word = (exp_type == 4) ? 16'hF000 : 16'h0FFF;
          exp_bad = 0; m_t++;
          if (m_t == 2 * PAT * REPS) m_st = 0;
        end
      endcase
      m_tpend = (m_tpend && !started) || train_req;
      exp_ready = (m_st == 1);
    end
  end

  // stream source: holds the front word until accepted
  always @(negedge clk) begin
    if (q.size() > 0) begin
      in_valid = 1; in_data = q[0].d; in_eop = q[0].e; in_err = q[0].r;
    end else begin
      in_valid = 0; in_data = '0; in_eop = 0; in_err = 0;
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      string tag;
      checks++;
      if (out_type !== 3'(exp_type) || out_word !== exp_word ||
          dip4_bad !== 1'(exp_bad) || in_ready !== 1'(exp_ready)) begin
        tag = cur_req;
        if (out_type === 3'(exp_type) && exp_type < 2 && out_word[3:0] !== exp_word[3:0])
          tag = (exp_bad != 0) ? "R8" : "R6";
        failures++;
        $display("FAIL %s t=%0t type=%0d/%0d word=%h/%h bad=%0d/%0d ready=%0d/%0d (actual/expected)",
                 tag, $time, out_type, exp_type, out_word, exp_word, dip4_bad, exp_bad,
                 in_ready, exp_ready);
      end
    end
  end

  function automatic logic [15:0] nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:8];
  endfunction

  task automatic push_pkt(input int n, input bit eop_last, input int err_at);
    for (int i = 0; i < n; i++) begin
      wd_t w;
      w.d = nxt(); w.e = eop_last && (i == n - 1); w.r = (i == err_at);
      q.push_back(w);
      if (i == err_at) break;
    end
  endtask

  task automatic drain();
    while (!(q.size() == 0 && m_st == 0)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_train();
    @(negedge clk) train_req = 1;
    @(negedge clk) train_req = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    checks++;
    if (out_type !== 3'd0 || out_word !== 16'h0 || dip4_bad !== 1'b0 || in_ready !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset type=%0d word=%h bad=%0d ready=%0d expected 0/0000/0/0",
               out_type, out_word, dip4_bad, in_ready);
    end
    rst_n = 1; chk_on = 1;
    cur_req = "R2"; repeat (5) @(negedge clk);            // empty FIFO -> idle
    cur_req = "R3"; grant = 1; push_pkt(3, 1, -1); drain();
    cur_req = "R4"; push_pkt(20, 1, -1); drain();         // 8,8,4 bursts
    cur_req = "R7"; push_pkt(8, 1, -1); push_pkt(9, 1, -1); drain();
    cur_req = "R2"; grant = 0; push_pkt(5, 1, -1);
    repeat (6) @(negedge clk); grant = 1; drain();
    cur_req = "R5"; push_pkt(12, 1, -1);
    while (m_st != 1) @(negedge clk);
    idle_req = 1; repeat (15) @(negedge clk); idle_req = 0; drain();
    cur_req = "R8"; push_pkt(6, 1, 2); drain();           // error mid-packet
    push_pkt(4, 1, 3); drain();                            // error on eop word
    push_pkt(3, 0, 1); push_pkt(5, 1, -1); drain();        // error then next packet
    cur_req = "R4"; push_pkt(5, 0, -1);                   // underrun mid-packet
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk); push_pkt(5, 1, -1); drain();
    cur_req = "R9"; push_pkt(20, 1, -1);
    while (m_st != 1) @(negedge clk);
    pulse_train();
    while (m_st != 2) @(negedge clk);
    while (m_st == 2) @(negedge clk);
    cur_req = "R10"; drain();
    cur_req = "R9"; idle_req = 1; push_pkt(4, 1, -1);
    repeat (3) @(negedge clk); pulse_train();
    while (m_st != 2) @(negedge clk);
    while (m_st == 2) @(negedge clk);
    cur_req = "R10"; repeat (3) @(negedge clk);
    idle_req = 0; drain();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule